// File: doc/BRIEF.md
# Byte Hamming Check-Bit Generator

This block takes one 8-bit data byte and forms four Hamming check bits from fixed subsets of the byte, together with the parity of the whole byte. The whole-byte parity is then merged with an external parity bit and an even/odd select. The merged result is the gated parity output.

The gated parity result is captured in a one-bit register on every rising clock edge. That register can keep its value, or it can work as one stage of a serial scan ring by loading a serial input. The register drives a true error output and a complemented error output. The check bits, the whole-byte parity and the gated parity output are purely combinational. Only the error pair comes from the register.

Top module: `byte_chk_gen`

## Requirements
- R1: `chk_o[0]` is the XOR of data bits 1, 3, 5 and 7.
- R2: `chk_o[1]` is the XOR of data bits 2, 3, 6 and 7.
- R3: `chk_o[2]` is the XOR of data bits 4, 5, 6 and 7.
- R4: `chk_o[3]` is the XOR of data bits 1, 2, 4 and 7. Data bit 0 has no effect on any bit of `chk_o`.
- R5: `word_par_o` is the XOR of all eight data bits.
- R6: `gen_par_o` equals `word_par_o` XOR `ext_par_i` XOR `odd_sel_i`. With `odd_sel_i` low (even parity), `gen_par_o` is 0 when the byte and `ext_par_i` together hold an even number of ones.
- R7: When `shift_i` is high at a rising edge, the register loads `scan_i`, whatever the values of `hold_i` and `en_i`.
- R8: When `shift_i` is low and `hold_i` is high at a rising edge, the register keeps its value.
- R9: When `shift_i` and `hold_i` are both low at a rising edge, the register loads `gen_par_o` AND `en_i`. It therefore loads 0 when `en_i` is low.
- R10: When `rst_i` is high at a rising edge, the register clears to 0. `err_o` is then 0 and `err_n_o` is 1.
- R11: `err_n_o` is always the complement of `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| data_i | input | 8 | Data byte |
| ext_par_i | input | 1 | External parity bit merged into the gated parity |
| odd_sel_i | input | 1 | Parity sense: 0 selects even, 1 selects odd |
| en_i | input | 1 | Gates the parity value loaded into the register |
| hold_i | input | 1 | Keep the register value |
| shift_i | input | 1 | Load the scan input into the register |
| scan_i | input | 1 | Serial scan input |
| chk_o | output | 4 | Hamming check bits |
| word_par_o | output | 1 | Parity of the whole byte |
| gen_par_o | output | 1 | Gated parity output |
| err_o | output | 1 | Registered error output, true polarity |
| err_n_o | output | 1 | Registered error output, complemented |

## Verification
The assertions check the register's next-state rules on every cycle: reset clears it, shift loads the scan input, hold keeps its value, and the gated load takes effect otherwise. They also check that the two error outputs stay complementary. The combinational masks need the bench's scenarios:
- walking-one bytes show which data bits feed which check bit, and that data bit 0 feeds none of them;
- exhaustive byte sweeps with every select and parity combination show the parity sense.

Shift chains across several cycles are shown only by the scenarios, as is the priority of shift over hold when both are asserted.

// File: rtl/byte_chk_pkg.sv
package byte_chk_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;

  // Membership of data bits in each check bit.
  localparam logic [CHK_W-1:0][DATA_W-1:0] CHK_MASK = '{
    8'b1001_0110,  // check 3: bits 1,2,4,7
    8'b1111_0000,  // check 2: bits 4,5,6,7
    8'b1100_1100,  // check 1: bits 2,3,6,7
    8'b1010_1010   // check 0: bits 1,3,5,7
  };

  typedef enum logic [1:0] {LD_SCAN, LD_KEEP, LD_PAR} ld_sel_e;

  function automatic logic masked_par(input logic [DATA_W-1:0] d,
                                      input logic [DATA_W-1:0] m);
    return ^(d & m);
  endfunction

  function automatic ld_sel_e pick_load(input logic shift, input logic hold);
    if (shift)     return LD_SCAN;
    else if (hold) return LD_KEEP;
    else           return LD_PAR;
  endfunction
endpackage

// File: rtl/byte_chk_tree.sv
module byte_chk_tree
  import byte_chk_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              word_par_o
);
  for (genvar g = 0; g < CHK_W; g++) begin : g_chk
    assign chk_o[g] = masked_par(data_i, CHK_MASK[g]);
  end
  assign word_par_o = ^data_i;

  // R4: bit 0 is in no mask
  initial begin
    for (int k = 0; k < CHK_W; k++)
      a_b0_excluded_r4: assert (CHK_MASK[k][0] == 1'b0);
  end
endmodule

// File: rtl/byte_par_gate.sv
module byte_par_gate (
  input  logic word_par_i,
  input  logic ext_par_i,
  input  logic odd_sel_i,
  output logic gen_par_o
);
  assign gen_par_o = word_par_i ^ ext_par_i ^ odd_sel_i;
endmodule

// File: rtl/byte_scan_cell.sv
module byte_scan_cell
  import byte_chk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic par_i,
  input  logic en_i,
  input  logic hold_i,
  input  logic shift_i,
  input  logic scan_i,
  output logic q_o,
  output logic q_n_o
);
  ld_sel_e sel;
  logic    gated_par;
  logic    q_q;

  assign sel       = pick_load(shift_i, hold_i);
  assign gated_par = par_i & en_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) q_q <= 1'b0;
    else begin
      unique case (sel)
        LD_SCAN: q_q <= scan_i;
        LD_KEEP: q_q <= q_q;
        default: q_q <= gated_par;
      endcase
    end
  end

  assign q_o   = q_q;
  assign q_n_o = ~q_q;

  p_rst_clear_r10: assert property (@(posedge clk_i) rst_i |=> (q_o == 1'b0));
  p_shift_load_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    shift_i |=> (q_o == $past(scan_i)));
  p_hold_keep_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!shift_i && hold_i) |=> $stable(q_o));
  p_par_load_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!shift_i && !hold_i) |=> (q_o == ($past(par_i) & $past(en_i))));
  p_pair_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    q_o != q_n_o);
endmodule

// File: rtl/byte_chk_gen.sv
module byte_chk_gen
  import byte_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ext_par_i,
  input  logic              odd_sel_i,
  input  logic              en_i,
  input  logic              hold_i,
  input  logic              shift_i,
  input  logic              scan_i,
  output logic [CHK_W-1:0]  chk_o,
  output logic              word_par_o,
  output logic              gen_par_o,
  output logic              err_o,
  output logic              err_n_o
);
  logic wpar;

  byte_chk_tree u_tree (.data_i(data_i), .chk_o(chk_o), .word_par_o(wpar));
  assign word_par_o = wpar;

  byte_par_gate u_gate (.word_par_i(wpar), .ext_par_i(ext_par_i),
                        .odd_sel_i(odd_sel_i), .gen_par_o(gen_par_o));

  byte_scan_cell u_cell (
    .clk_i(clk_i), .rst_i(rst_i), .par_i(gen_par_o), .en_i(en_i),
    .hold_i(hold_i), .shift_i(shift_i), .scan_i(scan_i),
    .q_o(err_o), .q_n_o(err_n_o));

  p_even_sense_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!odd_sel_i && ($countones({data_i, ext_par_i}) % 2 == 0)) |-> !gen_par_o);
endmodule

// File: tb/byte_chk_gen_tb_top.sv
module byte_chk_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [7:0] data = 0;
  logic ext_par = 0, odd_sel = 0, en = 0, hold = 0, shift = 0, scan = 0;
  logic [3:0] chk;
  logic word_par, gen_par, err, err_n;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_chk_gen dut_i (
    .clk_i(clk), .rst_i(rst), .data_i(data), .ext_par_i(ext_par),
    .odd_sel_i(odd_sel), .en_i(en), .hold_i(hold), .shift_i(shift),
    .scan_i(scan), .chk_o(chk), .word_par_o(word_par), .gen_par_o(gen_par),
    .err_o(err), .err_n_o(err_n));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_chk(input logic [7:0] d);
    ref_chk[0] = d[1] ^ d[3] ^ d[5] ^ d[7];
    ref_chk[1] = d[2] ^ d[3] ^ d[6] ^ d[7];
    ref_chk[2] = d[4] ^ d[5] ^ d[6] ^ d[7];
    ref_chk[3] = d[1] ^ d[2] ^ d[4] ^ d[7];
  endfunction

  // Drive at the falling edge, sample after the next rising edge.
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1; shift = 1; scan = 1; tick(); tick();
    check("R10 err", {7'b0, err}, 8'h0);
    check("R10 err_n", {7'b0, err_n}, 8'h1);
    rst = 0; shift = 0; scan = 0;
  endtask

  task automatic t_walk();
    for (int b = 0; b < 8; b++) begin
      data = 8'h1 << b; #1;
      check("R1", {7'b0, chk[0]}, {7'b0, (b==1||b==3||b==5||b==7)});
      check("R2", {7'b0, chk[1]}, {7'b0, (b==2||b==3||b==6||b==7)});
      check("R3", {7'b0, chk[2]}, {7'b0, (b>=4)});
      check("R4", {7'b0, chk[3]}, {7'b0, (b==1||b==2||b==4||b==7)});
    end
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 4; s++) begin
        int ones;
        data = v[7:0]; ext_par = s[0]; odd_sel = s[1]; #1;
        ones = $countones(v[7:0]) + s[0];
        check("R1-4 chk", {4'b0, chk}, {4'b0, ref_chk(v[7:0])});
        check("R5", {7'b0, word_par}, {7'b0, ($countones(v[7:0]) % 2 == 1)});
        check("R6", {7'b0, gen_par}, {7'b0, ((ones % 2 == 1) != s[1])});
      end
    end
  endtask

  task automatic t_load();
    hold = 0; shift = 0;
    data = 8'h01; ext_par = 0; odd_sel = 0; en = 1; tick();
    check("R9 load", {7'b0, err}, 8'h1);
    check("R11", {7'b0, err_n}, 8'h0);
    en = 0; tick();
    check("R9 gated", {7'b0, err}, 8'h0);
    en = 1; odd_sel = 1; tick();
    check("R9 odd", {7'b0, err}, 8'h0);
    odd_sel = 0; tick();
    check("R9 reload", {7'b0, err}, 8'h1);
  endtask

  task automatic t_hold();
    hold = 1; data = 8'h00; en = 1; tick(); tick();
    check("R8 keep1", {7'b0, err}, 8'h1);
    hold = 0; tick(); hold = 1; data = 8'h01; tick();
    check("R8 keep0", {7'b0, err}, 8'h0);
    check("R11 hold", {7'b0, err_n}, 8'h1);
    hold = 0;
  endtask

  task automatic t_shift();
    logic [3:0] pat = 4'b1011;
    shift = 1; hold = 1; en = 0;
    for (int i = 0; i < 4; i++) begin
      scan = pat[i]; tick();
      check("R7 scan", {7'b0, err}, {7'b0, pat[i]});
      check("R11 scan", {7'b0, err_n}, {7'b0, ~pat[i]});
    end
    shift = 0; hold = 0;
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset(); t_walk(); t_sweep(); @(negedge clk);
        t_load(); t_hold(); t_shift();
        rst = 1; tick();
        check("R10 again", {7'b0, err}, 8'h0);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule